// File: doc/BRIEF.md
# Sequencer Pause and Interrupt Controller

This block sits between a host register bus and an embedded sequencer. It holds the host control byte, runs the handshake that stops the sequencer, and latches the sequencer's four interrupt sources into a status byte. The host can read that byte and clears it with write-one-to-clear. A pause request only takes effect while the sequencer is outside a critical section. The pause bit the host reads back shows whether the sequencer has actually stopped, not what the host asked for. When the sequencer raises a coded interrupt it halts itself at once. It stays halted until the host writes a control value with the pause bit at zero.

The host reaches two addresses. Address 0 is the control byte. Address 1 reads the status byte, and a write to it is the clear mask. Reads are combinational from `host_raddr`. Writes take effect on the clock edge that samples `host_wr`. Events from the sequencer are single-cycle pulses.

The pause handshake is a three-state machine:
- PS_RUN: the sequencer runs.
- PS_WAIT: a request is pending while the critical section is held.
- PS_HALT: the sequencer is stopped.

Its transitions:
- RUN→HALT when a request meets no critical section, on a sequencer interrupt, or on chip reset.
- RUN→WAIT when a request meets a critical section.
- WAIT→HALT when the critical section ends, on a sequencer interrupt, or on chip reset.
- WAIT→RUN when the request is withdrawn.
- HALT→RUN when the request bit is zero.

Top module: `seq_host_ctl`

## Requirements
- R1: After reset the sequencer is halted (`seq_halt`=1). The control byte reads 0x04, the status byte reads 0x00, `int_pend`=0, and `irq`=1 (interrupts disabled in low-active mode).
- R2: The control byte has these bits: bit6 power-down, bit4 software interrupt, bit3 IRQ mode, bit2 pause, bit1 interrupt enable, bit0 chip reset. Writing bit2=1 outside a critical section halts the sequencer on the clock after the write. Bit2 then reads 1.
- R3: While `seq_crit` is high, a pause request stays pending, bit2 reads 0 and `seq_halt` stays 0. The sequencer halts on the first clock on which `seq_crit` is low.
- R4: A `seq_int_evt` pulse halts the sequencer on that clock edge, even inside a critical section. It stays halted, with clearing of the status having no effect on that, until the host writes the control byte with bit2=0.
- R5: The status byte is laid out as follows: bit3 break-address fault, bit2 bus event, bit1 command complete, bit0 sequencer interrupt, bits7:4 the 4-bit reason code. Each event pulse sets its bit. The code is captured with each sequencer interrupt and held until the next one.
- R6: A write to address 1 clears each status bit whose mask bit is 1. Mask bits at 0 leave their bit unchanged. An event and its clear in the same cycle leave the bit set.
- R7: `int_pend` is the OR of status bits 0, 1 and 2. Neither the break-address bit nor the software interrupt drives it.
- R8: The active level is interrupt-enable AND (any status bit 3:0 OR the software-interrupt bit). With IRQ mode 1, `irq` equals the active level. With IRQ mode 0, `irq` is its inverse.
- R9: Writing control bit0=1 clears all status bits and the reason code, restores the control byte to 0x04 and halts the sequencer on that edge. Bit0 always reads 0.
- R10: `pwr_down` follows control bit6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | Write address: 0 control, 1 status clear |
| host_wdata | input | 8 | Write data |
| host_raddr | input | 1 | Read address: 0 control, 1 status |
| host_rdata | output | 8 | Read data |
| seq_crit | input | 1 | Sequencer is inside a critical section |
| seq_int_evt | input | 1 | Sequencer interrupt pulse |
| seq_int_code | input | 4 | Reason code sampled with `seq_int_evt` |
| cmd_done_evt | input | 1 | Command-complete pulse |
| bus_evt | input | 1 | Bus-event interrupt pulse |
| brk_evt | input | 1 | Break-address fault pulse |
| seq_halt | output | 1 | Sequencer stop command / halted state |
| irq | output | 1 | Interrupt line, polarity set by IRQ mode |
| int_pend | output | 1 | Polling summary |
| pwr_down | output | 1 | Power-down control |

## Verification
The key collision is between a status bit being set by an event pulse and the host clearing that same bit in the same clock. The bench drives `cmd_done_evt` and a clear write with mask bit1 on one edge, then reads the status byte. The bit must still be set. A second collision pits a sequencer interrupt against a pause request that is held off by the critical section. The bench raises `seq_int_evt` with `seq_crit` high. It expects the halt on that edge, and expects the halt to persist after the status is cleared, until the host writes pause at zero.

// File: rtl/seq_ctl_pkg.sv
package seq_ctl_pkg;
    localparam int DATA_W  = 8;
    localparam int CODE_W  = 4;
    localparam int NSRC    = 4;

    // control byte bit positions
    localparam int C_PWRDN = 6;
    localparam int C_SWINT = 4;
    localparam int C_IRQMS = 3;
    localparam int C_PAUSE = 2;
    localparam int C_INTEN = 1;
    localparam int C_CHRST = 0;

    // status bit positions
    localparam int S_SEQ = 0;
    localparam int S_CMD = 1;
    localparam int S_BUS = 2;
    localparam int S_BRK = 3;

    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_WAIT = 2'd1,
        PS_HALT = 2'd2
    } pstate_t;
endpackage

// File: rtl/shc_ctrl_reg.sv
module shc_ctrl_reg
    import seq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              seq_int_evt,
    output logic              chip_rst,
    output logic              pause_req,
    output logic              int_en,
    output logic              irq_mode,
    output logic              swint,
    output logic              pwr_dn
);
    assign chip_rst = wr_ctl && wdata[C_CHRST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pause_req <= 1'b1;
            int_en    <= 1'b0;
            irq_mode  <= 1'b0;
            swint     <= 1'b0;
            pwr_dn    <= 1'b0;
        end else if (chip_rst) begin
            pause_req <= 1'b1;
            int_en    <= 1'b0;
            irq_mode  <= 1'b0;
            swint     <= 1'b0;
            pwr_dn    <= 1'b0;
        end else begin
            if (wr_ctl) begin
                int_en   <= wdata[C_INTEN];
                irq_mode <= wdata[C_IRQMS];
                swint    <= wdata[C_SWINT];
                pwr_dn   <= wdata[C_PWRDN];
            end
            // a sequencer interrupt holds the request over a host write
            if (seq_int_evt)
                pause_req <= 1'b1;
            else if (wr_ctl)
                pause_req <= wdata[C_PAUSE];
        end
    end

    // R4: a sequencer interrupt leaves the request asserted
    a_r4_req_set: assert property (@(posedge clk) disable iff (!rst_n)
        seq_int_evt |=> pause_req);
    // R9: chip reset restores the control state
    a_r9_ctl_reset: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |=> (pause_req && !int_en && !swint && !pwr_dn && !irq_mode));
endmodule

// File: rtl/shc_pause_fsm.sv
module shc_pause_fsm
    import seq_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pause_req,
    input  logic seq_crit,
    input  logic seq_int_evt,
    input  logic chip_rst,
    output logic halted
);
    pstate_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN: begin
                if (seq_int_evt || chip_rst)  state_d = PS_HALT;
                else if (pause_req && !seq_crit) state_d = PS_HALT;
                else if (pause_req)           state_d = PS_WAIT;
            end
            PS_WAIT: begin
                if (seq_int_evt || chip_rst)  state_d = PS_HALT;
                else if (!pause_req)          state_d = PS_RUN;
                else if (!seq_crit)           state_d = PS_HALT;
            end
            PS_HALT: begin
                if (!pause_req && !seq_int_evt && !chip_rst) state_d = PS_RUN;
            end
            default: state_d = PS_HALT;
        endcase
    end

    always_comb begin
        halted = (state_q == PS_HALT);
    end

    // R3: a request inside the critical section does not stop the sequencer
    a_r3_crit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && seq_crit && !seq_int_evt && !chip_rst) |=> !halted);
    // R4: a sequencer interrupt halts at once
    a_r4_int_halts: assert property (@(posedge clk) disable iff (!rst_n)
        seq_int_evt |=> halted);
    // R4: halted stays while the request remains
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && pause_req) |=> halted);
    // R2: request outside critical section halts next cycle
    a_r2_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && !seq_crit) |=> halted);
endmodule

// File: rtl/shc_int_status.sv
module shc_int_status
    import seq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt,
    input  logic [CODE_W-1:0] code_in,
    input  logic              clr_wr,
    input  logic [NSRC-1:0]   clr_mask,
    input  logic              chip_rst,
    output logic [NSRC-1:0]   flags,
    output logic [CODE_W-1:0] code_q
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              flags[i] <= 1'b0;
            else if (chip_rst)       flags[i] <= 1'b0;
            else if (evt[i])         flags[i] <= 1'b1;
            else if (clr_wr && clr_mask[i]) flags[i] <= 1'b0;
        end

        // R5: an event sets its bit
        a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && !chip_rst) |=> flags[i]);
        // R6: a clear without a coincident event removes the bit
        a_r6_clr: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && clr_mask[i] && !evt[i]) |=> !flags[i]);
        // R6: a bit not addressed by the clear is held
        a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !chip_rst && !(clr_wr && clr_mask[i])) |=> flags[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              code_q <= '0;
        else if (chip_rst)       code_q <= '0;
        else if (evt[S_SEQ])     code_q <= code_in;
    end

    // R5: the code holds between sequencer interrupts
    a_r5_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt[S_SEQ] && !chip_rst) |=> $stable(code_q));
endmodule

// File: rtl/seq_host_ctl.sv
module seq_host_ctl
    import seq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_raddr,
    output logic [7:0]        host_rdata,
    input  logic              seq_crit,
    input  logic              seq_int_evt,
    input  logic [3:0]        seq_int_code,
    input  logic              cmd_done_evt,
    input  logic              bus_evt,
    input  logic              brk_evt,
    output logic              seq_halt,
    output logic              irq,
    output logic              int_pend,
    output logic              pwr_down
);
    logic            wr_ctl, wr_clr, chip_rst;
    logic            pause_req, int_en, irq_mode, swint, pwr_dn;
    logic [NSRC-1:0] evt, flags;
    logic [CODE_W-1:0] code_q;
    logic            active;

    assign wr_ctl = host_wr && !host_addr;
    assign wr_clr = host_wr &&  host_addr;

    always_comb begin
        evt        = '0;
        evt[S_SEQ] = seq_int_evt;
        evt[S_CMD] = cmd_done_evt;
        evt[S_BUS] = bus_evt;
        evt[S_BRK] = brk_evt;
    end

    shc_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wdata(host_wdata),
        .seq_int_evt(seq_int_evt), .chip_rst(chip_rst), .pause_req(pause_req),
        .int_en(int_en), .irq_mode(irq_mode), .swint(swint), .pwr_dn(pwr_dn)
    );

    shc_pause_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pause_req(pause_req), .seq_crit(seq_crit),
        .seq_int_evt(seq_int_evt), .chip_rst(chip_rst), .halted(seq_halt)
    );

    shc_int_status u_stat (
        .clk(clk), .rst_n(rst_n), .evt(evt), .code_in(seq_int_code),
        .clr_wr(wr_clr), .clr_mask(host_wdata[NSRC-1:0]), .chip_rst(chip_rst),
        .flags(flags), .code_q(code_q)
    );

    assign active   = int_en && ((|flags) || swint);
    assign irq      = irq_mode ? active : !active;
    assign int_pend = flags[S_SEQ] | flags[S_CMD] | flags[S_BUS];
    assign pwr_down = pwr_dn;

    always_comb begin
        host_rdata = '0;
        if (host_raddr) begin
            host_rdata = {code_q, flags};
        end else begin
            host_rdata[C_PWRDN] = pwr_dn;
            host_rdata[C_SWINT] = swint;
            host_rdata[C_IRQMS] = irq_mode;
            host_rdata[C_PAUSE] = seq_halt;
            host_rdata[C_INTEN] = int_en;
        end
    end

    // R8: enabled, high mode and a pending status drive the line high
    a_r8_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en && irq_mode && (|flags)) |-> irq);
    // R8: disabled interrupts leave the line at its idle level
    a_r8_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> (irq != irq_mode));
    // R7: the summary never rises from the break-address bit alone
    a_r7_pend: assert property (@(posedge clk) disable iff (!rst_n)
        int_pend |-> (|flags[2:0]));
    // R9: chip reset leaves status empty and sequencer halted
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |=> (flags == '0 && seq_halt));
endmodule

// File: tb/seq_host_ctl_bench.sv
`timescale 1ns/1ps
module seq_host_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_addr = 1'b0, host_raddr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       seq_crit = 1'b0, seq_int_evt = 1'b0, cmd_done_evt = 1'b0;
    logic       bus_evt = 1'b0, brk_evt = 1'b0;
    logic [3:0] seq_int_code = '0;
    logic       seq_halt, irq, int_pend, pwr_down;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    seq_host_ctl u_seq_host_ctl (.*);

    // {events brk,bus,cmd,seq ; code ; clear mask ; expected status}
    localparam logic [19:0] VEC [6] = '{
        {4'b0001, 4'h3, 4'b0000, 8'h31},
        {4'b0010, 4'h5, 4'b0000, 8'h32},
        {4'b0100, 4'h0, 4'b0100, 8'h30},
        {4'b1001, 4'h4, 4'b0001, 8'h48},
        {4'b1111, 4'h2, 4'b1010, 8'h25},
        {4'b0110, 4'h7, 4'b0000, 8'h26}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        host_raddr = a;
        #1 v = host_rdata;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] ev, input logic [3:0] code);
        @(negedge clk);
        {brk_evt, bus_evt, cmd_done_evt, seq_int_evt} = ev;
        seq_int_code = code;
        @(negedge clk);
        {brk_evt, bus_evt, cmd_done_evt, seq_int_evt} = '0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        rd(1'b0, v); chk("R1 ctl", v, 8'h04);
        rd(1'b1, v); chk("R1 status", v, 8'h00);
        chk("R1 halt/irq/pend", {5'b0, seq_halt, irq, int_pend}, 8'h06);

        // R5 R6 table of events and clears
        for (int i = 0; i < 6; i++) begin
            pulse(VEC[i][19:16], VEC[i][15:12]);
            wr(1'b1, {4'h0, VEC[i][11:8]});
            rd(1'b1, v); chk($sformatf("R5/R6 vec%0d", i), v, VEC[i][7:0]);
            wr(1'b1, 8'h0F);
        end

        // R2 unpause then pause outside critical section
        wr(1'b0, 8'h0A); tick();
        chk("R2 running", {7'b0, seq_halt}, 8'h00);
        rd(1'b0, v); chk("R2 ctl run", v, 8'h0A);
        chk("R8 mode1 idle", {7'b0, irq}, 8'h00);
        wr(1'b0, 8'h0E); tick();
        rd(1'b0, v); chk("R2 pause reads 1", v, 8'h0E);
        wr(1'b0, 8'h0A); tick();

        // R3 request during critical section
        seq_crit = 1'b1;
        wr(1'b0, 8'h0E); tick(); tick();
        rd(1'b0, v); chk("R3 pending reads 0", v, 8'h0A);
        chk("R3 not halted", {7'b0, seq_halt}, 8'h00);
        seq_crit = 1'b0;
        tick();
        chk("R3 halts after crit", {7'b0, seq_halt}, 8'h01);
        wr(1'b0, 8'h0A); tick();

        // R4 sequencer interrupt inside critical section
        seq_crit = 1'b1;
        pulse(4'b0001, 4'h4);
        chk("R4 immediate halt", {7'b0, seq_halt}, 8'h01);
        rd(1'b1, v); chk("R4/R5 status", v, 8'h41);
        wr(1'b1, 8'h01); tick(); tick();
        chk("R4 stays halted", {7'b0, seq_halt}, 8'h01);
        wr(1'b0, 8'h0A); tick();
        chk("R4 resumes", {7'b0, seq_halt}, 8'h00);
        seq_crit = 1'b0;

        // R7 R8 interrupt line
        pulse(4'b0010, 4'h9);
        chk("R7 pend cmd", {7'b0, int_pend}, 8'h01);
        chk("R8 irq high", {7'b0, irq}, 8'h01);
        wr(1'b0, 8'h02);
        chk("R8 irq low mode", {7'b0, irq}, 8'h00);
        wr(1'b0, 8'h08);
        chk("R8 disabled", {7'b0, irq}, 8'h00);
        wr(1'b1, 8'h02);
        pulse(4'b1000, 4'h0);
        wr(1'b0, 8'h0A);
        chk("R7 brk no pend", {7'b0, int_pend}, 8'h00);
        chk("R8 brk irq", {7'b0, irq}, 8'h01);
        wr(1'b1, 8'h08);
        chk("R8 irq drops", {7'b0, irq}, 8'h00);
        wr(1'b0, 8'h1A);
        chk("R8 swint irq", {6'b0, irq, int_pend}, 8'h02);
        wr(1'b0, 8'h0A);

        // R6 event and clear in one cycle
        @(negedge clk);
        cmd_done_evt = 1'b1; host_wr = 1'b1; host_addr = 1'b1; host_wdata = 8'h02;
        @(negedge clk);
        cmd_done_evt = 1'b0; host_wr = 1'b0;
        rd(1'b1, v); chk("R6 set wins", v, 8'h42);
        wr(1'b1, 8'h02);
        pulse(4'b0100, 4'h0);
        wr(1'b1, 8'h0B);
        rd(1'b1, v); chk("R6 zero mask keeps", v, 8'h44);
        wr(1'b1, 8'h04);

        // R10 power down
        wr(1'b0, 8'h4A);
        chk("R10 pwr", {7'b0, pwr_down}, 8'h01);
        rd(1'b0, v); chk("R10 ctl", v, 8'h4A);

        // R9 chip reset
        pulse(4'b0011, 4'h6);
        wr(1'b0, 8'h01);
        rd(1'b1, v); chk("R9 status", v, 8'h00);
        rd(1'b0, v); chk("R9 ctl", v, 8'h04);
        chk("R9 halt/pwr", {6'b0, seq_halt, pwr_down}, 8'h02);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule